// File: doc/BRIEF.md
# Gate Scheduler Error Status and Interrupt Unit

This unit sits beside a time-aware transmit gate scheduler. The scheduler reports five kinds of events, each as a single-cycle pulse:

- a gate-control fault;
- head-of-line blocking caused by the schedule, which comes with a mask of the affected queues;
- head-of-line blocking caused by frame size, which comes with a queue number and a frame length;
- a base-time programming error;
- completion of a switch to the software-owned list.

The unit keeps each event as sticky state. A 32-bit register port lets software read that state and clear it. The unit also reduces the enabled events to a single registered interrupt line.

Software reaches five word registers through the port:

- a status word, which includes a saturating retry loop count;
- a per-queue schedule-blocking bitmap;
- a per-queue size-blocking bitmap;
- a capture word with the length and queue of the first size-blocking event;
- an interrupt enable word.

Reads return their data one cycle after the read strobe, with a valid flag. The parameter `NUM_Q` sets the number of transmit queues, from 1 to 8. It sets the width of both bitmaps and the width of the queue field in the capture word.

Top module: `tsn_gate_err_irq`

## Requirements
- R1: After reset, every register reads as zero and `irq_o` is low.
- R2: The status word is at byte offset 0x00. Bit 4 is the gate-control fault, bit 1 is the base-time error and bit 0 is the list-switch completion. Each of these bits is set by its event pulse and stays set until software writes a 1 to it. If an event and a clear arrive in the same cycle, the bit stays set.
- R3: The bitmap at offset 0x04 holds one bit per queue. A schedule-blocking pulse ORs its queue mask into the bitmap. Writing 1s clears the matching bits. Status bit 3 is the OR of this bitmap.
- R4: The bitmap at offset 0x08 holds one bit per queue. A size-blocking pulse sets the bit of its queue number. Status bit 2 is the OR of this bitmap. A pulse whose queue number is NUM_Q or higher changes nothing.
- R5: The capture word is at offset 0x0C. It holds the frame length in bits 14:0 and the queue number from bit 16 upward. The queue field is 1 bit wide for up to 2 queues, 2 bits for up to 4 queues, and 3 bits otherwise. The word is loaded only by a size event that arrives while the size bitmap is empty, so it keeps the first event until software empties the bitmap.
- R6: Status bits 15:8 count base-time error pulses and stop at 255. Writing a 1 to status bit 1 resets the count to zero. A pulse in the same cycle as that clear increments the count instead.
- R7: The enable word is at offset 0x10. It uses the same bit positions 4..0 as the status flags, one enable per flag. Its other bits read as zero. Writing zero masks every source.
- R8: `irq_o` is the OR of (status bits 4..0 AND enable), registered once. It follows the state of the previous cycle.
- R9: Writes to status bits 3, 2 and 15:8 and to the capture word have no effect. Reads of any other offset, including unaligned ones, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_gate_err | input | 1 | Gate-control fault pulse |
| ev_sched_hlb | input | 1 | Schedule head-of-line blocking pulse |
| ev_sched_mask | input | NUM_Q | Queues blocked by the schedule |
| ev_size_hlb | input | 1 | Size head-of-line blocking pulse |
| ev_size_qnum | input | 1..3 | Queue number of the blocked frame |
| ev_size_len | input | 15 | Length of the blocked frame |
| ev_btime_err | input | 1 | Base-time error pulse |
| ev_list_done | input | 1 | Switch to the software list completed |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| reg_rdata | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `NUM_Q = 6`. With that value the queue field is 3 bits wide, the widest case. It also leaves queue numbers 6 and 7 encodable but out of range, so the ignore rule can be tested. The retry counter is driven past 255 to reach saturation. Same-cycle event-and-clear collisions are driven on both the flag bits and the loop count.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int LEN_W = 15;
  localparam int CNT_W = 8;

  localparam int B_GATE  = 4;
  localparam int B_SCHED = 3;
  localparam int B_SIZE  = 2;
  localparam int B_BTIME = 1;
  localparam int B_LIST  = 0;

  localparam int CAP_Q_LSB = 16;
  localparam int CNT_LSB   = 8;

  typedef enum logic [2:0] {
    SEL_STAT,
    SEL_SCHED,
    SEL_SIZE,
    SEL_CAP,
    SEL_EN,
    SEL_NONE
  } reg_sel_e;

  function automatic int qfield_w(input int nq);
    if (nq > 4)      return 3;
    else if (nq > 2) return 2;
    else             return 1;
  endfunction

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    case (a)
      8'h00:   return SEL_STAT;
      8'h04:   return SEL_SCHED;
      8'h08:   return SEL_SIZE;
      8'h0C:   return SEL_CAP;
      8'h10:   return SEL_EN;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tsi_w1c_bank.sv
module tsi_w1c_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  // A set in the same cycle as a clear keeps the bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

  // R2, R3, R4: a new event is visible on the next cycle
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R2, R3: a bit only falls when it was cleared
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));

endmodule

// File: rtl/tsi_sat_cnt.sv
module tsi_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (inc_i) cnt <= bump(cnt);
    else if (clr_i) cnt <= '0;
  end

  assign cnt_o = cnt;

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == TOP && inc_i) |=> (cnt_o == TOP));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_o == '0));

  p_never_drops_on_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (cnt_o != '0));

endmodule

// File: rtl/tsi_size_capture.sv
module tsi_size_capture #(
  parameter int QF_W  = 3,
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             bm_empty_i,
  input  logic [QF_W-1:0]  qnum_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [QF_W-1:0]  cap_q_o,
  output logic [LEN_W-1:0] cap_len_o
);

  logic             load;
  logic [QF_W-1:0]  cap_q;
  logic [LEN_W-1:0] cap_len;

  assign load = ev_i && bm_empty_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_len <= '0;
    end else if (load) begin
      cap_q   <= qnum_i;
      cap_len <= len_i;
    end
  end

  assign cap_q_o   = cap_q;
  assign cap_len_o = cap_len;

  p_first_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_empty_i |=> ($stable(cap_q_o) && $stable(cap_len_o)));

  p_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && bm_empty_i) |=> (cap_len_o == $past(len_i)));

endmodule

// File: rtl/tsn_gate_err_irq.sv
module tsn_gate_err_irq
  import tsi_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_gate_err,
  input  logic                          ev_sched_hlb,
  input  logic [NUM_Q-1:0]              ev_sched_mask,
  input  logic                          ev_size_hlb,
  input  logic [qfield_w(NUM_Q)-1:0]    ev_size_qnum,
  input  logic [14:0]                   ev_size_len,
  input  logic                          ev_btime_err,
  input  logic                          ev_list_done,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [7:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic                          reg_rvalid,
  output logic [31:0]                   reg_rdata,
  output logic                          irq_o
);

  localparam int QF_W  = qfield_w(NUM_Q);
  localparam int N_FLG = 3;

  // ---------------- register port decode ----------------
  reg_sel_e sel;
  logic     wr_stat, wr_sched, wr_size, wr_en;
  logic     wdata_unused;

  assign sel      = decode_addr(reg_addr);
  assign wr_stat  = reg_wr && (sel == SEL_STAT);
  assign wr_sched = reg_wr && (sel == SEL_SCHED);
  assign wr_size  = reg_wr && (sel == SEL_SIZE);
  assign wr_en    = reg_wr && (sel == SEL_EN);
  assign wdata_unused = ^reg_wdata;

  // ---------------- sticky single flags: gate, btime, list ----------------
  logic [N_FLG-1:0] flg_set, flg_clr, flg_q;

  assign flg_set = {ev_gate_err, ev_btime_err, ev_list_done};
  assign flg_clr = wr_stat ? {reg_wdata[B_GATE], reg_wdata[B_BTIME], reg_wdata[B_LIST]}
                           : '0;

  tsi_w1c_bank #(.W(N_FLG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flg_set),
    .clr_i (flg_clr),
    .q_o   (flg_q)
  );

  // ---------------- per-queue bitmaps ----------------
  logic [NUM_Q-1:0] sched_set, sched_clr, sched_bm;
  logic [NUM_Q-1:0] size_set, size_clr, size_bm;
  logic             size_ev_ok;

  assign sched_set = ev_sched_hlb ? ev_sched_mask : '0;
  assign sched_clr = wr_sched ? reg_wdata[NUM_Q-1:0] : '0;
  assign size_ev_ok = ev_size_hlb && (int'(ev_size_qnum) < NUM_Q);
  assign size_clr  = wr_size ? reg_wdata[NUM_Q-1:0] : '0;

  always_comb begin
    size_set = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (size_ev_ok && (int'(ev_size_qnum) == i)) size_set[i] = 1'b1;
    end
  end

  tsi_w1c_bank #(.W(NUM_Q)) u_sched_bm (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sched_set),
    .clr_i (sched_clr),
    .q_o   (sched_bm)
  );

  tsi_w1c_bank #(.W(NUM_Q)) u_size_bm (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (size_set),
    .clr_i (size_clr),
    .q_o   (size_bm)
  );

  // ---------------- size capture ----------------
  logic [QF_W-1:0]  cap_q;
  logic [LEN_W-1:0] cap_len;

  tsi_size_capture #(.QF_W(QF_W), .LEN_W(LEN_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (size_ev_ok),
    .bm_empty_i (size_bm == '0),
    .qnum_i     (ev_size_qnum),
    .len_i      (ev_size_len),
    .cap_q_o    (cap_q),
    .cap_len_o  (cap_len)
  );

  // ---------------- base-time loop count ----------------
  logic [CNT_W-1:0] loop_cnt;
  logic             btime_clr;

  assign btime_clr = wr_stat && reg_wdata[B_BTIME];

  tsi_sat_cnt #(.W(CNT_W)) u_loop (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (ev_btime_err),
    .clr_i (btime_clr),
    .cnt_o (loop_cnt)
  );

  // ---------------- enable register ----------------
  logic [4:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata[4:0];
  end

  // ---------------- status assembly and interrupt ----------------
  logic [4:0]  stat_flags;
  logic [31:0] stat_word, cap_word;
  logic        irq_q;

  always_comb begin
    stat_flags          = '0;
    stat_flags[B_GATE]  = flg_q[2];
    stat_flags[B_SCHED] = |sched_bm;
    stat_flags[B_SIZE]  = |size_bm;
    stat_flags[B_BTIME] = flg_q[1];
    stat_flags[B_LIST]  = flg_q[0];

    stat_word = '0;
    stat_word[4:0] = stat_flags;
    stat_word[CNT_LSB +: CNT_W] = loop_cnt;

    cap_word = '0;
    cap_word[LEN_W-1:0] = cap_len;
    cap_word[CAP_Q_LSB +: QF_W] = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_flags & en_q);
  end

  assign irq_o = irq_q;

  // ---------------- read path ----------------
  logic [31:0] rd_mux, rdata_q;
  logic        rvalid_q;

  always_comb begin
    case (sel)
      SEL_STAT:  rd_mux = stat_word;
      SEL_SCHED: rd_mux = 32'(sched_bm);
      SEL_SIZE:  rd_mux = 32'(size_bm);
      SEL_CAP:   rd_mux = cap_word;
      SEL_EN:    rd_mux = 32'(en_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = rdata_q;

  // ---------------- assertions ----------------
  p_irq_reach_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_gate_err && en_q[B_GATE] && !wr_en) |=> ##1 irq_o);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);

  p_sched_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sched_hlb && ev_sched_mask != '0) |=> stat_word[B_SCHED]);

  p_bad_queue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_size_hlb && !size_ev_ok && size_clr == '0) |=> $stable(size_bm));

  p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

endmodule

// File: tb/test_tsn_gate_err_irq.sv
module test_tsn_gate_err_irq;

  localparam int NQ = 6;
  localparam int QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_gate_err = 0, ev_sched_hlb = 0, ev_size_hlb = 0, ev_btime_err = 0, ev_list_done = 0;
  logic [NQ-1:0] ev_sched_mask = '0;
  logic [QW-1:0] ev_size_qnum = '0;
  logic [14:0]   ev_size_len = '0;
  logic          reg_wr = 0, reg_rd = 0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_rvalid;
  logic [31:0]   reg_rdata;
  logic          irq_o;

  always #2 clk = ~clk;

  tsn_gate_err_irq #(.NUM_Q(NQ)) i_tsn_gate_err_irq (
    .clk (clk), .rst_n (rst_n),
    .ev_gate_err (ev_gate_err), .ev_sched_hlb (ev_sched_hlb),
    .ev_sched_mask (ev_sched_mask), .ev_size_hlb (ev_size_hlb),
    .ev_size_qnum (ev_size_qnum), .ev_size_len (ev_size_len),
    .ev_btime_err (ev_btime_err), .ev_list_done (ev_list_done),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rvalid (reg_rvalid),
    .reg_rdata (reg_rdata), .irq_o (irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sbq[$];
  int n_chk = 0;
  int n_err = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (sbq.size() == 0) begin
        check(reg_rdata, 32'hDEAD_BEEF, "R9 unexpected read data");
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(reg_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_btime(input int n);
    for (int i = 0; i < n; i++) begin
      ev_btime_err = 1;
      @(negedge clk);
      ev_btime_err = 0;
    end
  endtask

  task automatic pulse_size(input logic [QW-1:0] q, input logic [14:0] len);
    ev_size_hlb = 1; ev_size_qnum = q; ev_size_len = len;
    @(negedge clk);
    ev_size_hlb = 0;
  endtask

  task automatic pulse_sched(input logic [NQ-1:0] m);
    ev_sched_hlb = 1; ev_sched_mask = m;
    @(negedge clk);
    ev_sched_hlb = 0; ev_sched_mask = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check({31'd0, irq_o}, 0, "R1 irq after reset");
    rd(8'h00, 0, "R1 status");
    rd(8'h04, 0, "R1 sched bitmap");
    rd(8'h08, 0, "R1 size bitmap");
    rd(8'h0C, 0, "R1 capture");
    rd(8'h10, 0, "R1 enable");

    // R7 enable register width
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h1F, "R7 enable readback");

    // R2 / R8 gate fault and irq latency
    ev_gate_err = 1; @(negedge clk); ev_gate_err = 0;
    check({31'd0, irq_o}, 0, "R8 irq one cycle late");
    idle(1);
    check({31'd0, irq_o}, 1, "R8 irq raised");
    rd(8'h00, 32'h10, "R2 gate flag set");
    wr(8'h00, 32'h10);
    idle(1);
    check({31'd0, irq_o}, 0, "R8 irq dropped after clear");
    rd(8'h00, 0, "R2 gate flag cleared");

    // R2 event wins over a clear in the same cycle
    ev_list_done = 1; @(negedge clk); ev_list_done = 0;
    ev_list_done = 1; reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h1;
    @(negedge clk);
    ev_list_done = 0; reg_wr = 0; reg_wdata = 0;
    rd(8'h00, 32'h01, "R2 list flag kept on collision");
    wr(8'h00, 32'h01);
    rd(8'h00, 0, "R2 list flag cleared");

    // R3 schedule bitmap
    pulse_sched(6'b100000);
    pulse_sched(6'b000101);
    rd(8'h04, 32'h25, "R3 bitmap OR");
    rd(8'h00, 32'h08, "R3 summary bit");
    wr(8'h00, 32'h0000_FF0C);
    rd(8'h00, 32'h08, "R9 summary write ignored");
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h24, "R3 partial clear");
    rd(8'h00, 32'h08, "R3 summary while bits remain");
    wr(8'h04, 32'h3F);
    rd(8'h04, 0, "R3 full clear");
    rd(8'h00, 0, "R3 summary falls");

    // R4 / R5 size bitmap and capture
    pulse_size(3'd3, 15'd100);
    rd(8'h08, 32'h08, "R4 size bit q3");
    rd(8'h0C, 32'h0003_0064, "R5 first capture");
    rd(8'h00, 32'h04, "R4 summary bit");
    pulse_size(3'd5, 15'd200);
    rd(8'h08, 32'h28, "R4 second queue");
    rd(8'h0C, 32'h0003_0064, "R5 capture holds first");
    pulse_size(3'd7, 15'd9);
    rd(8'h08, 32'h28, "R4 out-of-range queue ignored");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0003_0064, "R9 capture write ignored");
    wr(8'h08, 32'h3F);
    rd(8'h00, 0, "R4 summary falls");
    pulse_size(3'd1, 15'h7FFF);
    rd(8'h0C, 32'h0001_7FFF, "R5 recapture after empty");
    wr(8'h08, 32'h3F);

    // R6 loop count
    pulse_btime(3);
    rd(8'h00, 32'h0302, "R6 count three");
    wr(8'h00, 32'h02);
    rd(8'h00, 0, "R6 cleared to zero");
    pulse_btime(1);
    ev_btime_err = 1; reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h2;
    @(negedge clk);
    ev_btime_err = 0; reg_wr = 0; reg_wdata = 0;
    rd(8'h00, 32'h0202, "R6 event wins over clear");
    wr(8'h00, 32'h02);
    pulse_btime(260);
    rd(8'h00, 32'hFF02, "R6 saturated");
    wr(8'h00, 32'hFF00);
    rd(8'h00, 32'hFF02, "R9 count write ignored");

    // R7 / R8 masking
    wr(8'h10, 0);
    idle(2);
    check({31'd0, irq_o}, 0, "R7 all masked");
    wr(8'h10, 32'h01);
    idle(2);
    check({31'd0, irq_o}, 0, "R7 unrelated source masked");
    ev_list_done = 1; @(negedge clk); ev_list_done = 0;
    idle(1);
    check({31'd0, irq_o}, 1, "R8 enabled list source");

    // R9 unmapped reads
    rd(8'h14, 0, "R9 unmapped offset");
    rd(8'h02, 0, "R9 unaligned offset");

    idle(3);
    check(32'(sbq.size()), 0, "R9 scoreboard drained");
    finish_run();
  end

endmodule